// File: doc/BRIEF.md
# Register Override List Walker

The block works through a list of 32-bit override words in memory and carries out each one. A start pulse gives it the address of the first word. It then fetches words one at a time over a simple read port. The port holds a request and an address until the memory returns a valid strobe with the data. The two low bits of each word give its type. The block turns the word into a write on one of three destinations:

- a hardware-register port, which takes 16-bit or 32-bit values;
- an analog-interface port with two channels and 6-bit addresses;
- a parameter-table port, which takes byte or halfword writes.

A list can contain runs of array data. It can jump to a new segment in another memory region, and it ends with a terminator word. An optional engine-mode word may open the list. A malformed list stops the walk with an error status. A well-formed list ends with a done status.

Typical use is one pass over a configuration list after power-up or after a mode change. The block does one write per clock. The time a list takes is set by the memory latency, since every word needs its own fetch.

Top module: `ovrListWalker`

## Requirements
- R1: A start pulse with a list pointer of zero performs no read and no write, and `done` is high from the first clock edge after the pulse.
- R2: Each word is fetched by holding `rdReq` with a stable `rdAddr` until `rdValid`. Words in a segment are read at addresses that rise by 4, and array data words follow their array-start word.
- R3: A word with bits [1:0] = 00 writes the hardware register at address {word[15:2], 2'b00}. The data is word[31:16] with zero extension, and `hwWrWide` is 0.
- R4: A word with bits [1:0] = 10 writes the analog interface. The channel is bit 31 and the half-size (read-modify-write) flag is bit 30. The first write puts value [23:16] at address [29:24]. When bits [15:10] are nonzero, a second write in the next cycle puts value [9:2] at address [15:10], on the same channel and with the same flag.
- R5: A word with bits [1:0] = 11 and bits [3:2] = 00 writes parameter index [14:4] with value [31:16]. `parWrByte` copies bit 15, where 1 means an 8-bit write.
- R6: A word with bits [1:0] = 01 starts an array. The start index is [15:2], the element count is [29:16] and the kind is [31:30]. The next count words are elements, and each kind writes as follows:

  | Kind | Destination | Element value | Position step |
  |---|---|---|---|
  | 00 | hardware register at {index, 2'b00} | low 16 bits | index + 1 |
  | 01 | hardware register at {index, 2'b00}, full word, `hwWrWide` = 1 | whole word | index + 1 |
  | 10 | analog interface: channel index[7], half flag index[6], address index[5:0] | low 8 bits | address + 1, modulo 64 |
  | 11 | parameter, 16-bit write at index[10:0] | low 16 bits | index + 2 |

- R7: An array count of zero, or a count above `MAX_ARRAY_LEN`, ends the walk with `error`. No element of that array is written.
- R8: A word with bits [1:0] = 11, bits [3:2] = 11 and region bits [7:4] of 1, 2 or 3 moves the next fetch to a new segment. The bases are 0x2000_0000, 0x2100_0000 and 0xA000_0000 respectively, and the next address is the base plus word[31:8] × 4.
- R9: A segment-end word with region 0x0 or 0xF ends the walk with `done`.
- R10: An engine-mode word (bits [3:0] = 4'b0111) that is the first word of the list pulses `modeWrEn` with `modeCfg` = word[31:4]. In any later position, including after a segment jump, it ends the walk with `error`.
- R11: A type-11 word with bits [3:2] = 10, or a segment-end word with a region code other than 0, 1, 2, 3 or F, ends the walk with `error`.
- R12: After reset, `busy`, `done` and `error` are low. `busy` is high from the edge after an accepted start until the walk ends. At that point exactly one of `done` and `error` rises and stays high until the next start. A start pulse while `busy` is high is ignored.
- R13: At most one of the write strobes `hwWrEn`, `anaWrEn`, `parWrEn` and `modeWrEn` is high in any cycle, and none is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| listPtr | input | 32 | Address of the first list word, sampled at start |
| rdReq | output | 1 | Read request, held until rdValid |
| rdAddr | output | 32 | Byte address of the word being read |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data |
| hwWrEn | output | 1 | Hardware-register write strobe |
| hwWrAddr | output | 16 | Hardware-register byte address |
| hwWrData | output | 32 | Hardware-register write data |
| hwWrWide | output | 1 | 1: full 32-bit value; 0: 16-bit value |
| anaWrEn | output | 1 | Analog-interface write strobe |
| anaWrCh | output | 1 | Analog-interface channel |
| anaWrAddr | output | 6 | Analog-interface register address |
| anaWrData | output | 8 | Analog-interface write value |
| anaWrHalf | output | 1 | Half-size read-modify-write select |
| parWrEn | output | 1 | Parameter-table write strobe |
| parWrIdx | output | 11 | Parameter byte index |
| parWrData | output | 16 | Parameter value |
| parWrByte | output | 1 | 1: 8-bit write; 0: 16-bit write |
| modeWrEn | output | 1 | Engine-mode configuration strobe |
| modeCfg | output | 28 | Engine-mode configuration field |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk ended without error |
| error | output | 1 | Walk ended with a parameter error |

## Verification
The first list mixes every single-word type. It places a mode word first, uses analog words both with and without a second address, and sets the parameter byte flag both ways. This separates field extraction for each destination port.

A second list chains all four array kinds and then jumps segment. Its analog run starts at address 0x3F, which shows that the address wraps and the channel select holds across elements.

The error lists separate each error source from a clean end:
- an array count of zero;
- a count of one above the limit, next to a count exactly at the limit;
- a reserved subtype;
- a reserved region code;
- a mode word that arrives after a jump to the third region.

A pointer of zero and a start pulse in the middle of a walk test that the start input is sampled correctly.

// File: rtl/olPkg.sv
package olPkg;
  localparam int WORD_W     = 32;
  localparam int HW_ADDR_W  = 16;
  localparam int ANA_ADDR_W = 6;
  localparam int ANA_DATA_W = 8;
  localparam int PAR_IDX_W  = 11;
  localparam int PAR_DATA_W = 16;
  localparam int CNT_W      = 14;
  localparam int IDX_W      = 14;
  localparam int MODE_W     = WORD_W - 4;

  typedef enum logic [2:0] {
    stIdle, stFetch, stExec, stAna2, stDone, stErr
  } olState_t;

  typedef enum logic [1:0] {
    akHw16 = 2'b00, akHw32 = 2'b01, akAna = 2'b10, akPar = 2'b11
  } arrKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadPtr;
    logic latchWord;
    logic stepAddr;
    logic jumpSeg;
    logic startArr;
    logic arrStep;
    logic clearFirst;
    logic hwWr;
    logic anaWr1;
    logic anaWr2;
    logic parWr;
    logic modeWr;
  } olStrobe_t;

  function automatic logic [WORD_W-1:0] regionBase(input logic [3:0] code);
    case (code)
      4'h1:    regionBase = 32'h2000_0000;
      4'h2:    regionBase = 32'h2100_0000;
      4'h3:    regionBase = 32'hA000_0000;
      default: regionBase = '0;
    endcase
  endfunction
endpackage

// File: rtl/olDatapath.sv
module olDatapath
  import olPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  olStrobe_t             strb,
  input  logic [WORD_W-1:0]     listPtr,
  input  logic [WORD_W-1:0]     rdData,
  output logic [WORD_W-1:0]     curAddr,
  output logic [WORD_W-1:0]     entry,
  output logic                  inArr,
  output logic                  first,
  output logic                  hwWrEn,
  output logic [HW_ADDR_W-1:0]  hwWrAddr,
  output logic [WORD_W-1:0]     hwWrData,
  output logic                  hwWrWide,
  output logic                  anaWrEn,
  output logic                  anaWrCh,
  output logic [ANA_ADDR_W-1:0] anaWrAddr,
  output logic [ANA_DATA_W-1:0] anaWrData,
  output logic                  anaWrHalf,
  output logic                  parWrEn,
  output logic [PAR_IDX_W-1:0]  parWrIdx,
  output logic [PAR_DATA_W-1:0] parWrData,
  output logic                  parWrByte,
  output logic                  modeWrEn,
  output logic [MODE_W-1:0]     modeCfg
);
  arrKind_t         arrKind;
  logic [IDX_W-1:0] arrIdx;
  logic [IDX_W-1:0] arrIdxNext;
  logic [CNT_W-1:0] arrRemain;
  logic [WORD_W-1:0] segNext;

  assign segNext = regionBase(entry[7:4]) + {6'b0, entry[31:8], 2'b00};

  always_comb begin
    case (arrKind)
      akAna:   arrIdxNext = {arrIdx[IDX_W-1:ANA_ADDR_W], arrIdx[ANA_ADDR_W-1:0] + 6'd1};
      akPar:   arrIdxNext = arrIdx + 14'd2;
      default: arrIdxNext = arrIdx + 14'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      entry     <= '0;
      inArr     <= 1'b0;
      first     <= 1'b0;
      arrKind   <= akHw16;
      arrIdx    <= '0;
      arrRemain <= '0;
    end else begin
      if (strb.loadPtr) begin
        curAddr <= listPtr;
        inArr   <= 1'b0;
        first   <= 1'b1;
      end
      if (strb.latchWord)  entry   <= rdData;
      if (strb.stepAddr)   curAddr <= curAddr + 32'd4;
      if (strb.jumpSeg)    curAddr <= segNext;
      if (strb.clearFirst) first   <= 1'b0;
      if (strb.startArr) begin
        inArr     <= 1'b1;
        arrKind   <= arrKind_t'(entry[31:30]);
        arrIdx    <= entry[15:2];
        arrRemain <= entry[29:16];
      end
      if (strb.arrStep) begin
        arrRemain <= arrRemain - 14'd1;
        arrIdx    <= arrIdxNext;
        if (arrRemain == 14'd1) inArr <= 1'b0;
      end
    end
  end

  logic elemHw, elemAna, elemPar;
  assign elemHw  = strb.arrStep && (arrKind == akHw16 || arrKind == akHw32);
  assign elemAna = strb.arrStep && (arrKind == akAna);
  assign elemPar = strb.arrStep && (arrKind == akPar);

  assign hwWrEn   = strb.hwWr || elemHw;
  assign hwWrAddr = elemHw ? {arrIdx, 2'b00} : {entry[15:2], 2'b00};
  assign hwWrWide = elemHw && (arrKind == akHw32);
  assign hwWrData = !elemHw            ? {16'b0, entry[31:16]} :
                    (arrKind == akHw32) ? entry : {16'b0, entry[15:0]};

  assign anaWrEn   = strb.anaWr1 || strb.anaWr2 || elemAna;
  assign anaWrCh   = elemAna ? arrIdx[7] : entry[31];
  assign anaWrHalf = elemAna ? arrIdx[6] : entry[30];
  assign anaWrAddr = elemAna ? arrIdx[ANA_ADDR_W-1:0] :
                     strb.anaWr2 ? entry[15:10] : entry[29:24];
  assign anaWrData = elemAna ? entry[7:0] :
                     strb.anaWr2 ? entry[9:2] : entry[23:16];

  assign parWrEn   = strb.parWr || elemPar;
  assign parWrIdx  = elemPar ? arrIdx[PAR_IDX_W-1:0] : entry[14:4];
  assign parWrData = elemPar ? entry[15:0] : entry[31:16];
  assign parWrByte = !elemPar && entry[15];

  assign modeWrEn = strb.modeWr;
  assign modeCfg  = entry[31:4];
endmodule

// File: rtl/olControl.sv
module olControl
  import olPkg::*;
#(
  parameter int MAX_ARRAY_LEN = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              ptrNull,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] entry,
  input  logic              inArr,
  input  logic              first,
  output olStrobe_t         strb,
  output logic              rdReq,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ARRAY_LEN);

  olState_t state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic unusedBits;

  assign cnt        = entry[29:16];
  assign unusedBits = ^{entry[31:30], entry[9:8]};

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      stIdle, stDone, stErr: begin
        if (start) begin
          if (ptrNull) stateNext = stDone;
          else begin
            strb.loadPtr = 1'b1;
            stateNext    = stFetch;
          end
        end
      end
      stFetch: begin
        if (rdValid) begin
          strb.latchWord = 1'b1;
          stateNext      = stExec;
        end
      end
      stExec: begin
        stateNext = stFetch;
        if (inArr) begin
          strb.arrStep  = 1'b1;
          strb.stepAddr = 1'b1;
        end else begin
          case (entry[1:0])
            2'b00: begin
              strb.hwWr       = 1'b1;
              strb.stepAddr   = 1'b1;
              strb.clearFirst = 1'b1;
            end
            2'b01: begin
              if (cnt == '0 || cnt > MAX_CNT) stateNext = stErr;
              else begin
                strb.startArr   = 1'b1;
                strb.stepAddr   = 1'b1;
                strb.clearFirst = 1'b1;
              end
            end
            2'b10: begin
              strb.anaWr1     = 1'b1;
              strb.stepAddr   = 1'b1;
              strb.clearFirst = 1'b1;
              if (entry[15:10] != '0) stateNext = stAna2;
            end
            default: begin
              case (entry[3:2])
                2'b00: begin
                  strb.parWr      = 1'b1;
                  strb.stepAddr   = 1'b1;
                  strb.clearFirst = 1'b1;
                end
                2'b01: begin
                  if (first) begin
                    strb.modeWr     = 1'b1;
                    strb.stepAddr   = 1'b1;
                    strb.clearFirst = 1'b1;
                  end else stateNext = stErr;
                end
                2'b10: stateNext = stErr;
                default: begin
                  case (entry[7:4])
                    4'h0, 4'hF: stateNext = stDone;
                    4'h1, 4'h2, 4'h3: begin
                      strb.jumpSeg    = 1'b1;
                      strb.clearFirst = 1'b1;
                    end
                    default: stateNext = stErr;
                  endcase
                end
              endcase
            end
          endcase
        end
      end
      stAna2: begin
        strb.anaWr2 = 1'b1;
        stateNext   = stFetch;
      end
      default: stateNext = stIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= stIdle;
    else       state <= stateNext;
  end

  assign rdReq = (state == stFetch);
  assign busy  = (state == stFetch) || (state == stExec) || (state == stAna2);
  assign done  = (state == stDone);
  assign error = (state == stErr);
endmodule

// File: rtl/ovrListWalker.sv
module ovrListWalker
  import olPkg::*;
#(
  parameter int MAX_ARRAY_LEN = 64
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] listPtr,
  output logic        rdReq,
  output logic [31:0] rdAddr,
  input  logic        rdValid,
  input  logic [31:0] rdData,
  output logic        hwWrEn,
  output logic [15:0] hwWrAddr,
  output logic [31:0] hwWrData,
  output logic        hwWrWide,
  output logic        anaWrEn,
  output logic        anaWrCh,
  output logic [5:0]  anaWrAddr,
  output logic [7:0]  anaWrData,
  output logic        anaWrHalf,
  output logic        parWrEn,
  output logic [10:0] parWrIdx,
  output logic [15:0] parWrData,
  output logic        parWrByte,
  output logic        modeWrEn,
  output logic [27:0] modeCfg,
  output logic        busy,
  output logic        done,
  output logic        error
);
  olStrobe_t         strb;
  logic [WORD_W-1:0] entry;
  logic              inArr;
  logic              first;
  logic              ptrNull;

  assign ptrNull = (listPtr == '0);

  olControl #(.MAX_ARRAY_LEN(MAX_ARRAY_LEN)) i_control (
    .clk(clk), .rstN(rstN), .start(start), .ptrNull(ptrNull),
    .rdValid(rdValid), .entry(entry), .inArr(inArr), .first(first),
    .strb(strb), .rdReq(rdReq), .busy(busy), .done(done), .error(error)
  );

  olDatapath i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .listPtr(listPtr), .rdData(rdData),
    .curAddr(rdAddr), .entry(entry), .inArr(inArr), .first(first),
    .hwWrEn(hwWrEn), .hwWrAddr(hwWrAddr), .hwWrData(hwWrData), .hwWrWide(hwWrWide),
    .anaWrEn(anaWrEn), .anaWrCh(anaWrCh), .anaWrAddr(anaWrAddr),
    .anaWrData(anaWrData), .anaWrHalf(anaWrHalf),
    .parWrEn(parWrEn), .parWrIdx(parWrIdx), .parWrData(parWrData),
    .parWrByte(parWrByte), .modeWrEn(modeWrEn), .modeCfg(modeCfg)
  );
endmodule

// File: rtl/ovrListWalkerChk.sv
module ovrListWalkerChk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] listPtr,
  input logic        rdReq,
  input logic [31:0] rdAddr,
  input logic        rdValid,
  input logic        hwWrEn,
  input logic [1:0]  hwAddrLow,
  input logic        anaWrEn,
  input logic        parWrEn,
  input logic        modeWrEn,
  input logic        busy,
  input logic        done,
  input logic        error
);
  a_r13_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hwWrEn, anaWrEn, parWrEn, modeWrEn}));

  a_r13_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(hwWrEn || anaWrEn || parWrEn || modeWrEn));

  a_r12_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done, error}));

  a_r12_end_status: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error));

  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  a_r2_read_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    hwWrEn |-> (hwAddrLow == 2'b00));

  a_r1_null_done: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && listPtr == 32'h0) |=> (done && !rdReq));
endmodule

bind ovrListWalker ovrListWalkerChk i_chk (
  .clk(clk), .rstN(rstN), .start(start), .listPtr(listPtr),
  .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
  .hwWrEn(hwWrEn), .hwAddrLow(hwWrAddr[1:0]), .anaWrEn(anaWrEn),
  .parWrEn(parWrEn), .modeWrEn(modeWrEn),
  .busy(busy), .done(done), .error(error)
);

// File: tb/test_ovrListWalker.sv
`timescale 1ns/1ps
module test_ovrListWalker;
  localparam int MAX_LEN = 64;
  localparam int LAT     = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] listPtr = '0;
  logic rdReq; logic [31:0] rdAddr;
  logic rdValid = 1'b0; logic [31:0] rdData = '0;
  logic hwWrEn, hwWrWide, anaWrEn, anaWrCh, anaWrHalf, parWrEn, parWrByte, modeWrEn;
  logic [15:0] hwWrAddr; logic [31:0] hwWrData;
  logic [5:0] anaWrAddr; logic [7:0] anaWrData;
  logic [10:0] parWrIdx; logic [15:0] parWrData;
  logic [27:0] modeCfg;
  logic busy, done, error;

  always #2.5 clk = ~clk;

  ovrListWalker #(.MAX_ARRAY_LEN(MAX_LEN)) i_ovrListWalker (
    .clk(clk), .rstN(rstN), .start(start), .listPtr(listPtr),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .hwWrEn(hwWrEn), .hwWrAddr(hwWrAddr), .hwWrData(hwWrData), .hwWrWide(hwWrWide),
    .anaWrEn(anaWrEn), .anaWrCh(anaWrCh), .anaWrAddr(anaWrAddr),
    .anaWrData(anaWrData), .anaWrHalf(anaWrHalf),
    .parWrEn(parWrEn), .parWrIdx(parWrIdx), .parWrData(parWrData), .parWrByte(parWrByte),
    .modeWrEn(modeWrEn), .modeCfg(modeCfg),
    .busy(busy), .done(done), .error(error)
  );

  typedef struct packed {
    logic [1:0]  k;   // 0 hw, 1 analog, 2 parameter, 3 mode
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  x;
  } ev_t;

  logic [31:0] mem [bit [31:0]];
  ev_t         expQ[$];
  logic [31:0] expRdQ[$];
  logic        expErr;
  logic [31:0] wp;
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic put(input logic [31:0] w);
    mem[wp] = w;
    wp += 32'd4;
  endtask

  function automatic logic [31:0] mkHw(input logic [15:0] a, input logic [15:0] v);
    return {v, a[15:2], 2'b00};
  endfunction
  function automatic logic [31:0] mkAna(input logic ch, input logic hf, input logic [5:0] a1,
      input logic [7:0] v1, input logic [5:0] a2, input logic [7:0] v2);
    return {ch, hf, a1, v1, a2, v2, 2'b10};
  endfunction
  function automatic logic [31:0] mkPar(input logic [10:0] i, input logic b, input logic [15:0] v);
    return {v, b, i, 2'b00, 2'b11};
  endfunction
  function automatic logic [31:0] mkArr(input logic [1:0] kind, input logic [13:0] s, input logic [13:0] c);
    return {kind, c, s, 2'b01};
  endfunction
  function automatic logic [31:0] mkEnd(input logic [3:0] r, input logic [23:0] off);
    return {off, r, 2'b11, 2'b11};
  endfunction
  function automatic logic [31:0] mkMode(input logic [27:0] cfg);
    return {cfg, 2'b01, 2'b11};
  endfunction

  function automatic ev_t mkEv(input logic [1:0] k, input logic [31:0] a,
                               input logic [31:0] d, input logic [1:0] x);
    ev_t e; e.k = k; e.a = a; e.d = d; e.x = x; return e;
  endfunction

  // behavioural reference: walk the list and queue expected reads and writes
  task automatic model(input logic [31:0] ptr);
    logic [31:0] a, w, d;
    logic [13:0] idx, cnt;
    logic [1:0] kind;
    bit first;
    expQ.delete(); expRdQ.delete(); expErr = 1'b0;
    if (ptr == 32'h0) return;
    a = ptr; first = 1'b1;
    for (int n = 0; n < 2000; n++) begin
      w = rdw(a); expRdQ.push_back(a); a += 32'd4;
      case (w[1:0])
        2'b00: expQ.push_back(mkEv(2'd0, {16'b0, w[15:2], 2'b00}, {16'b0, w[31:16]}, 2'b00));
        2'b01: begin
          cnt = w[29:16]; kind = w[31:30]; idx = w[15:2];
          if (cnt == 0 || int'(cnt) > MAX_LEN) begin expErr = 1'b1; return; end
          for (int i = 0; i < int'(cnt); i++) begin
            d = rdw(a); expRdQ.push_back(a); a += 32'd4;
            case (kind)
              2'b00: begin expQ.push_back(mkEv(2'd0, {16'b0, idx, 2'b00}, {16'b0, d[15:0]}, 2'b00)); idx += 14'd1; end
              2'b01: begin expQ.push_back(mkEv(2'd0, {16'b0, idx, 2'b00}, d, 2'b01)); idx += 14'd1; end
              2'b10: begin expQ.push_back(mkEv(2'd1, {26'b0, idx[5:0]}, {24'b0, d[7:0]}, {idx[7], idx[6]}));
                           idx[5:0] = idx[5:0] + 6'd1; end
              default: begin expQ.push_back(mkEv(2'd2, {21'b0, idx[10:0]}, {16'b0, d[15:0]}, 2'b00)); idx += 14'd2; end
            endcase
          end
        end
        2'b10: begin
          expQ.push_back(mkEv(2'd1, {26'b0, w[29:24]}, {24'b0, w[23:16]}, {w[31], w[30]}));
          if (w[15:10] != 0)
            expQ.push_back(mkEv(2'd1, {26'b0, w[15:10]}, {24'b0, w[9:2]}, {w[31], w[30]}));
        end
        default: begin
          case (w[3:2])
            2'b00: expQ.push_back(mkEv(2'd2, {21'b0, w[14:4]}, {16'b0, w[31:16]}, {1'b0, w[15]}));
            2'b01: begin
              if (!first) begin expErr = 1'b1; return; end
              expQ.push_back(mkEv(2'd3, 32'h0, {4'b0, w[31:4]}, 2'b00));
            end
            2'b10: begin expErr = 1'b1; return; end
            default: begin
              if (w[7:4] == 4'h0 || w[7:4] == 4'hF) return;
              else if (w[7:4] == 4'h1) a = 32'h2000_0000 + {6'b0, w[31:8], 2'b00};
              else if (w[7:4] == 4'h2) a = 32'h2100_0000 + {6'b0, w[31:8], 2'b00};
              else if (w[7:4] == 4'h3) a = 32'hA000_0000 + {6'b0, w[31:8], 2'b00};
              else begin expErr = 1'b1; return; end
            end
          endcase
        end
      endcase
      first = 1'b0;
    end
  endtask

  // memory responder with fixed latency; also checks read order (R2)
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (rdValid) begin
        rdValid = 1'b0; waitCnt = 0;
      end else if (rdReq) begin
        waitCnt++;
        if (waitCnt >= LAT) begin
          rdValid = 1'b1;
          rdData  = rdw(rdAddr);
          if (expRdQ.size() == 0) check(0, "R2", "unexpected read", {32'b0, rdAddr}, 64'h0);
          else begin
            logic [31:0] ea;
            ea = expRdQ.pop_front();
            check(rdAddr == ea, "R2", "read address", {32'b0, rdAddr}, {32'b0, ea});
          end
        end
      end else waitCnt = 0;
    end
  end

  // write monitor: compares every write cycle against the reference queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        int nEn;
        ev_t act, ex;
        string tag;
        nEn = int'(hwWrEn) + int'(anaWrEn) + int'(parWrEn) + int'(modeWrEn);
        if (nEn > 1) check(0, "R13", "simultaneous writes", 64'(nEn), 64'd1);
        if (nEn > 0 && !busy) check(0, "R13", "write while idle", 64'(nEn), 64'd0);
        if (nEn == 1) begin
          if (hwWrEn) begin act = mkEv(2'd0, {16'b0, hwWrAddr}, hwWrData, {1'b0, hwWrWide}); tag = "R3_R6_hw"; end
          else if (anaWrEn) begin act = mkEv(2'd1, {26'b0, anaWrAddr}, {24'b0, anaWrData}, {anaWrCh, anaWrHalf}); tag = "R4_R6_ana"; end
          else if (parWrEn) begin act = mkEv(2'd2, {21'b0, parWrIdx}, {16'b0, parWrData}, {1'b0, parWrByte}); tag = "R5_R6_par"; end
          else begin act = mkEv(2'd3, 32'h0, {4'b0, modeCfg}, 2'b00); tag = "R10_mode"; end
          if (expQ.size() == 0) check(0, tag, "unexpected write", act[65:2], 64'h0);
          else begin
            ex = expQ.pop_front();
            check(act == ex, tag, "write content", {act.a, act.d}, {ex.a, ex.d});
            check(act.k == ex.k && act.x == ex.x, tag, "write port/flags",
                  {60'b0, act.k, act.x}, {60'b0, ex.k, ex.x});
          end
        end
      end
    end
  end

  task automatic runList(input logic [31:0] ptr, input string req, input bit poke);
    model(ptr);
    @(negedge clk); start = 1'b1; listPtr = ptr;
    @(negedge clk); start = 1'b0;
    if (ptr == 32'h0) begin
      check(done && !busy && !rdReq, "R1", "null pointer completes at once",
            {61'b0, done, busy, rdReq}, 64'b100);
    end else begin
      check(busy, "R12", "busy after start", {63'b0, busy}, 64'd1);
      check(!done && !error, "R12", "old status cleared", {62'b0, done, error}, 64'd0);
    end
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; listPtr = 32'h0;   // R12: must be ignored while busy
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      check(busy, "R12", "start ignored while busy", {63'b0, busy}, 64'd1);
    end
    while (!(done || error)) @(negedge clk);
    check(error == expErr && done == !expErr, req, "end status",
          {62'b0, done, error}, {62'b0, !expErr, expErr});
    check(expQ.size() == 0, req, "missing writes", 64'(expQ.size()), 64'd0);
    check(expRdQ.size() == 0, "R2", "missing reads", 64'(expRdQ.size()), 64'd0);
    repeat (2) @(negedge clk);
    check(done == !expErr && error == expErr && !busy, "R12", "status held",
          {61'b0, busy, done, error}, {62'b0, !expErr, expErr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // list A: one of each single-word type, mode first (R3 R4 R5 R9 R10)
    wp = 32'h2000_0100;
    put(mkMode(28'h00A5C3E));
    put(mkHw(16'h1234, 16'hBEEF));
    put(mkAna(1'b0, 1'b0, 6'h11, 8'h5A, 6'h00, 8'h77));
    put(mkAna(1'b1, 1'b1, 6'h22, 8'hC3, 6'h23, 8'h3C));
    put(mkPar(11'h012, 1'b1, 16'h00FF));
    put(mkPar(11'h345, 1'b0, 16'hA55A));
    put(mkEnd(4'h0, 24'h0));
    // list B: all array kinds, then jump to region 2 (R6 R8 R9)
    wp = 32'h2000_0200;
    put(mkArr(2'b00, 14'h0100, 14'd3)); put(32'hDEAD_0001); put(32'h0000_8002); put(32'h1234_FFFF);
    put(mkArr(2'b01, 14'h0200, 14'd2)); put(32'hCAFE_F00D); put(32'h0123_4567);
    put(mkArr(2'b10, 14'h00BF, 14'd2)); put(32'h0000_00A1); put(32'hFFFF_FFB2);
    put(mkArr(2'b11, 14'h0010, 14'd2)); put(32'h0000_4444); put(32'h9999_5555);
    put(mkEnd(4'h2, 24'h000040));
    wp = 32'h2100_0100;
    put(mkHw(16'h0F0C, 16'h7777));
    put(mkEnd(4'hF, 24'h0));
    // list C: jump to region 3, then a late mode word (R8 R10)
    wp = 32'h2000_0300;
    put(mkHw(16'h0004, 16'h0001));
    put(mkEnd(4'h3, 24'h000010));
    wp = 32'hA000_0040;
    put(mkPar(11'h001, 1'b0, 16'h0202));
    put(mkMode(28'h0000001));
    // list D: zero count (R7)
    wp = 32'h2000_0400;
    put(mkHw(16'h0008, 16'h0101));
    put(mkArr(2'b00, 14'h0000, 14'd0));
    put(32'h0000_0000);
    // list E: count one above the limit (R7)
    wp = 32'h2000_0500;
    put(mkArr(2'b01, 14'h0000, 14'(MAX_LEN + 1)));
    // list F: count exactly at the limit (R6 R7)
    wp = 32'h2000_0600;
    put(mkArr(2'b00, 14'h0040, 14'(MAX_LEN)));
    for (int i = 0; i < MAX_LEN; i++) put(32'h0101_0101 * i);
    put(mkEnd(4'h0, 24'h0));
    // list G: reserved subtype (R11)
    wp = 32'h2000_0700;
    put(mkPar(11'h07F, 1'b1, 16'h0033));
    put({28'h0000001, 2'b10, 2'b11});
    // list H: reserved region code (R11)
    wp = 32'h2000_0800;
    put(mkEnd(4'h5, 24'h000001));

    repeat (5) @(negedge clk);
    check(!busy && !done && !error && !rdReq, "R12", "reset state",
          {60'b0, busy, done, error, rdReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !rdReq, "R12", "idle after reset",
          {60'b0, busy, done, error, rdReq}, 64'd0);

    runList(32'h0,         "R1",  1'b0);
    runList(32'h2000_0100, "R10", 1'b0);
    runList(32'h2000_0200, "R9",  1'b0);
    runList(32'h2000_0300, "R10", 1'b0);
    runList(32'h2000_0400, "R7",  1'b0);
    runList(32'h2000_0500, "R7",  1'b0);
    runList(32'h2000_0600, "R6",  1'b0);
    runList(32'h2000_0700, "R11", 1'b0);
    runList(32'h2000_0800, "R11", 1'b0);
    runList(32'h2000_0100, "R12", 1'b1);
    runList(32'h0,         "R1",  1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule